// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives two-channel serial audio as a slave. An external source supplies a bit clock, a frame clock and one data line. The receiver rebuilds the left and right samples as parallel words of `DATA_W` bits and pulses a strobe once per completed frame. All three serial inputs are brought into the system clock domain through synchronizer stages. Each bit is taken on the rising edge of the bit clock.

Static configuration inputs set the following:
- the framing: I2S, left-justified or right-justified;
- the word length: 16, 18, 20 or 24 bits;
- the bit order: MSB first or LSB first;
- which received slot feeds each output channel;
- whether a frame-clock transition arriving too early in a slot is discarded.

A slot is 32 bit periods, so the bit clock runs at 64 times the frame rate. Shorter words are left-aligned in the output and padded with zeros.

Top module: `aud_serial_rx`

## Requirements
- R1: While `rst_n` is low and after reset until the first frame completes, `left_o` and `right_o` are zero and `valid_o` is low.
- R2: With `fmt_i` = 0 (I2S), the left slot is the one with the frame clock low. The MSB is the second bit sampled after the frame-clock transition.
- R3: With `fmt_i` = 1 (left-justified), the left slot is the one with the frame clock high. The MSB is the first bit sampled after the transition. Code 3 behaves the same as code 1.
- R4: With `fmt_i` = 2 (right-justified), the left slot is the one with the frame clock high. The word's last bit falls on bit 31 of the 32-bit slot, so the word starts at bit 32 minus the word length.
- R5: `wlen_i` selects the word length: 0 = 16, 1 = 18, 2 = 20, 3 = 24 bits. The received word is placed in the top bits of each output, and the lower bits are zero.
- R6: With `lsb_first_i` = 1, the first bit of each word is its LSB. With `lsb_first_i` = 0, the first bit is its MSB.
- R7: `map_left_i` = 1 drives `left_o` from the right slot instead of the left slot. `map_right_i` = 1 drives `right_o` from the left slot instead of the right slot.
- R8: `valid_o` is high for exactly one system clock per frame. It goes high after the right word of a frame whose left word was also received, and the outputs are updated in that same cycle. The outputs hold their values at all other times.
- R9: With `guard_en_i` = 1, a frame-clock transition seen fewer than `GUARD_BITS` bit clocks after the last accepted slot start is ignored. The received words stay intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial bit clock; data is sampled on its rising edge |
| lrck_i | input | 1 | Frame clock selecting the channel slot |
| sdata_i | input | 1 | Serial audio data |
| fmt_i | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified |
| wlen_i | input | 2 | Word length code: 16, 18, 20 or 24 bits |
| lsb_first_i | input | 1 | 1 selects LSB-first bit order |
| map_left_i | input | 1 | 1 routes the right slot to `left_o` |
| map_right_i | input | 1 | 1 routes the left slot to `right_o` |
| guard_en_i | input | 1 | Enables rejection of early frame-clock transitions |
| left_o | output | DATA_W | Left output sample, left-aligned |
| right_o | output | DATA_W | Right output sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe per completed frame |

## Verification
A table of frames covers every framing with differing word lengths, both bit orders and all four mapping combinations. Each frame carries distinct left and right words. An error in the start position, the bit order, the zero padding or the slot routing therefore gives a different output word.

Directed frames then inject a one-bit frame-clock glitch early in the right slot, and separately early in the left slot, with the guard enabled. Correct words and a single strobe show that the glitch did not restart a slot. The strobe count is compared with the number of frames sent, which separates a one-cycle strobe from a longer one.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

   typedef enum logic [1:0] {
      FMT_I2S   = 2'd0,
      FMT_LEFTJ = 2'd1,
      FMT_RIGHT = 2'd2,
      FMT_RSVD  = 2'd3
   } frame_fmt_e;

   function automatic int unsigned word_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 16;
         2'd1:    return 18;
         2'd2:    return 20;
         default: return 24;
      endcase
   endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic lrck_i,
   input  logic sdata_i,
   output logic bit_stb,
   output logic lr_smp,
   output logic dat_smp
);

   logic [STAGES:0]   s_sclk;
   logic [STAGES-1:0] s_lr;
   logic [STAGES-1:0] s_dat;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("aud_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_sclk <= '0;
         s_lr   <= '0;
         s_dat  <= '0;
      end else begin
         s_sclk <= {s_sclk[STAGES-1:0], sclk_i};
         s_lr   <= {s_lr[STAGES-2:0], lrck_i};
         s_dat  <= {s_dat[STAGES-2:0], sdata_i};
      end
   end

   assign bit_stb = s_sclk[STAGES-1] & ~s_sclk[STAGES];
   assign lr_smp  = s_lr[STAGES-1];
   assign dat_smp = s_dat[STAGES-1];

endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
   import aud_rx_pkg::*;
#(
   parameter int DATA_W     = 24,
   parameter int SLOT_BITS  = 32,
   parameter int GUARD_BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              lr_smp,
   input  logic              dat_smp,
   input  logic [1:0]        fmt,
   input  logic [1:0]        wcode,
   input  logic              lsb_first,
   input  logic              guard_en,
   output logic              word_done,
   output logic              word_right,
   output logic [DATA_W-1:0] word_data
);

   localparam int CNT_W = $clog2(2 * SLOT_BITS);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] GUARD_V = CNT_W'(GUARD_BITS);

   logic              lr_cur;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] acc;

   logic              lr_edge, boundary, lr_new, in_word, is_last, new_left;
   logic [CNT_W-1:0]  idx, start_v, last_v;
   logic [DATA_W-1:0] acc_base, acc_nxt;
   int unsigned       wbits;

   always_comb begin
      wbits = word_bits(wcode);
      case (frame_fmt_e'(fmt))
         FMT_I2S:   start_v = CNT_W'(1);
         FMT_RIGHT: start_v = CNT_W'(SLOT_BITS - wbits);
         default:   start_v = '0;
      endcase
      last_v   = start_v + CNT_W'(wbits - 1);
      lr_edge  = bit_stb && (lr_smp != lr_cur);
      boundary = lr_edge && !(guard_en && (cnt < GUARD_V));
      lr_new   = boundary ? lr_smp : lr_cur;
      if (boundary)            idx = '0;
      else if (cnt == CNT_MAX) idx = CNT_MAX;
      else                     idx = cnt + 1'b1;
      in_word  = (idx >= start_v) && (idx <= last_v);
      is_last  = (idx == last_v);
      acc_base = boundary ? '0 : acc;
      acc_nxt  = lsb_first ? {dat_smp, acc_base[DATA_W-1:1]}
                           : {acc_base[DATA_W-2:0], dat_smp};
      new_left = (frame_fmt_e'(fmt) == FMT_I2S) ? !lr_new : lr_new;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lr_cur <= 1'b0;
         cnt    <= CNT_MAX;
         acc    <= '0;
      end else if (bit_stb) begin
         lr_cur <= lr_new;
         cnt    <= idx;
         if (in_word)       acc <= acc_nxt;
         else if (boundary) acc <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_done  <= 1'b0;
         word_right <= 1'b0;
         word_data  <= '0;
      end else begin
         word_done <= bit_stb && in_word && is_last;
         if (bit_stb && in_word && is_last) begin
            word_right <= !new_left;
            word_data  <= lsb_first ? acc_nxt : (acc_nxt << (DATA_W - wbits));
         end
      end
   end

   // R9: an early transition with the guard on leaves the slot level unchanged
   a_r9_guard_holds_level: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && guard_en && (lr_smp != lr_cur) && (cnt < GUARD_V))
      |=> (lr_cur == $past(lr_cur)));

   // R5: a 16-bit word leaves the low pad bits at zero
   a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && (wcode == 2'd0)) |-> (word_data[DATA_W-17:0] == '0));

endmodule

// File: rtl/aud_rx_route.sv
module aud_rx_route #(
   parameter int DATA_W = 24
) (
   input  logic              swap,
   input  logic [DATA_W-1:0] own_word,
   input  logic [DATA_W-1:0] other_word,
   output logic [DATA_W-1:0] pick
);

   assign pick = swap ? other_word : own_word;

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx #(
   parameter int DATA_W      = 24,
   parameter int SLOT_BITS   = 32,
   parameter int SYNC_STAGES = 2,
   parameter int GUARD_BITS  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              lrck_i,
   input  logic              sdata_i,
   input  logic [1:0]        fmt_i,
   input  logic [1:0]        wlen_i,
   input  logic              lsb_first_i,
   input  logic              map_left_i,
   input  logic              map_right_i,
   input  logic              guard_en_i,
   output logic [DATA_W-1:0] left_o,
   output logic [DATA_W-1:0] right_o,
   output logic              valid_o
);

   localparam int NCH = 2;

   generate
      if (DATA_W < 24) begin : g_bad_width
         $error("aud_serial_rx: DATA_W must hold a 24-bit word");
      end
      if (SLOT_BITS <= DATA_W) begin : g_bad_slot
         $error("aud_serial_rx: SLOT_BITS must exceed DATA_W");
      end
      if (GUARD_BITS < 1 || GUARD_BITS >= SLOT_BITS) begin : g_bad_guard
         $error("aud_serial_rx: GUARD_BITS out of range");
      end
   endgenerate

   logic              bit_stb, lr_smp, dat_smp;
   logic              word_done, word_right;
   logic [DATA_W-1:0] word_data;
   logic [DATA_W-1:0] held_left;
   logic              left_seen;
   logic [DATA_W-1:0] slot_word [NCH];
   logic [DATA_W-1:0] routed    [NCH];
   logic              swap_sel  [NCH];

   aud_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_i  (sclk_i),
      .lrck_i  (lrck_i),
      .sdata_i (sdata_i),
      .bit_stb (bit_stb),
      .lr_smp  (lr_smp),
      .dat_smp (dat_smp)
   );

   aud_rx_framer #(
      .DATA_W     (DATA_W),
      .SLOT_BITS  (SLOT_BITS),
      .GUARD_BITS (GUARD_BITS)
   ) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_stb    (bit_stb),
      .lr_smp     (lr_smp),
      .dat_smp    (dat_smp),
      .fmt        (fmt_i),
      .wcode      (wlen_i),
      .lsb_first  (lsb_first_i),
      .guard_en   (guard_en_i),
      .word_done  (word_done),
      .word_right (word_right),
      .word_data  (word_data)
   );

   assign slot_word[0] = held_left;
   assign slot_word[1] = word_data;
   assign swap_sel[0]  = map_left_i;
   assign swap_sel[1]  = map_right_i;

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_route
         aud_rx_route #(.DATA_W(DATA_W)) u_route (
            .swap       (swap_sel[ch]),
            .own_word   (slot_word[ch]),
            .other_word (slot_word[NCH-1-ch]),
            .pick       (routed[ch])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_left <= '0;
         left_seen <= 1'b0;
         left_o    <= '0;
         right_o   <= '0;
         valid_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (word_done && !word_right) begin
            held_left <= word_data;
            left_seen <= 1'b1;
         end else if (word_done && word_right && left_seen) begin
            left_o    <= routed[0];
            right_o   <= routed[1];
            valid_o   <= 1'b1;
            left_seen <= 1'b0;
         end
      end
   end

   // R8: strobe lasts one cycle
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R8: outputs only change together with the strobe
   a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

   // R8: strobe follows a completed right word
   a_r8_after_right: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(word_done && word_right));

   // R7: with no left swap, the left output carries the stored left word
   a_r7_left_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !$past(map_left_i)) |-> (left_o == $past(held_left)));

endmodule

// File: tb/sim_aud_serial_rx.sv
module sim_aud_serial_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
   logic [1:0]  fmt = 2'd0, wlen = 2'd3;
   logic        lsbf = 1'b0, mapl = 1'b0, mapr = 1'b0, guard = 1'b0;
   logic [23:0] left_o, right_o;
   logic        valid_o;

   int checks = 0;
   int errors = 0;
   int vcnt = 0;
   logic [23:0] cap_l = '0, cap_r = '0;

   always #10 clk = ~clk;

   aud_serial_rx u0 (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .lrck_i(lrck), .sdata_i(sdata),
      .fmt_i(fmt), .wlen_i(wlen), .lsb_first_i(lsbf), .map_left_i(mapl),
      .map_right_i(mapr), .guard_en_i(guard),
      .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
   );

   always @(posedge clk) begin
      if (rst_n && valid_o) begin
         vcnt  <= vcnt + 1;
         cap_l <= left_o;
         cap_r <= right_o;
      end
   end

   // fmt(2) wlen(2) lsbf mapl mapr left(24) right(24)
   localparam int NVEC = 9;
   localparam logic [54:0] VEC [NVEC] = '{
      {2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 24'hA5C3F1, 24'h3C5A96},
      {2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 24'h00BEEF, 24'h001234},
      {2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 24'h0ABCDE, 24'h054321},
      {2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 24'h02D1E7, 24'h01F00F},
      {2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 24'h00C0DE, 24'h00F00D},
      {2'd2, 2'd3, 1'b1, 1'b0, 1'b0, 24'hE1D2C3, 24'h1A2B3C},
      {2'd2, 2'd2, 1'b0, 1'b1, 1'b1, 24'h0FEDCB, 24'h0A0B0C},
      {2'd1, 2'd3, 1'b0, 1'b1, 1'b0, 24'h123456, 24'h654321},
      {2'd0, 2'd1, 1'b1, 1'b0, 1'b1, 24'h03ABCD, 24'h001234}
   };

   function automatic int wbits(input logic [1:0] c);
      case (c)
         2'd0: return 16;
         2'd1: return 18;
         2'd2: return 20;
         default: return 24;
      endcase
   endfunction

   function automatic string fmt_tag(input logic [1:0] f);
      if (f == 2'd0) return "R2";
      if (f == 2'd2) return "R4";
      return "R3";
   endfunction

   function automatic logic [23:0] align(input logic [23:0] w, input logic [1:0] c);
      int n;
      logic [23:0] m;
      n = wbits(c);
      m = (24'h1 << n) - 24'h1;
      if (n == 24) m = 24'hFFFFFF;
      return (w & m) << (24 - n);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bit_out(input logic lv, input logic d);
      @(negedge clk);
      sclk  = 1'b0;
      lrck  = lv;
      sdata = d;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   // glitch_slot: 0 left, 1 right, -1 none; glitch_idx: bit index of the glitch
   task automatic send_frame(input logic [1:0] f, input logic [1:0] c, input logic lf,
                             input logic [23:0] lw, input logic [23:0] rw,
                             input int glitch_slot, input int glitch_idx);
      int n, st;
      logic left_lv;
      n  = wbits(c);
      st = (f == 2'd0) ? 1 : ((f == 2'd2) ? 32 - n : 0);
      left_lv = (f == 2'd0) ? 1'b0 : 1'b1;
      bit_out(~left_lv, 1'b0);
      for (int s = 0; s < 2; s++) begin
         for (int i = 0; i < 32; i++) begin
            logic lv, d;
            logic [23:0] w;
            w  = (s == 0) ? lw : rw;
            lv = (s == 0) ? left_lv : ~left_lv;
            if (s == glitch_slot && i == glitch_idx) lv = ~lv;
            d = 1'b0;
            if (i >= st && i < st + n)
               d = lf ? w[i - st] : w[n - 1 - (i - st)];
            bit_out(lv, d);
         end
      end
      repeat (12) @(negedge clk);
   endtask

   task automatic run_frame(input logic [1:0] f, input logic [1:0] c, input logic lf,
                            input logic ml, input logic mr,
                            input logic [23:0] lw, input logic [23:0] rw,
                            input int gs, input int gi, input string tag);
      int v0;
      logic [23:0] el, er;
      fmt = f; wlen = c; lsbf = lf; mapl = ml; mapr = mr;
      v0 = vcnt;
      send_frame(f, c, lf, lw, rw, gs, gi);
      el = ml ? align(rw, c) : align(lw, c);
      er = mr ? align(lw, c) : align(rw, c);
      chk(vcnt == v0 + 1, {"R8 strobe count ", tag}, 24'(vcnt - v0), 24'd1);
      chk(cap_l == el, {"left ", tag}, cap_l, el);
      chk(cap_r == er, {"right ", tag}, cap_r, er);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(valid_o == 1'b0, "R1 valid in reset", 24'(valid_o), 24'd0);
      chk(left_o == '0, "R1 left in reset", left_o, '0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(right_o == '0 && valid_o == 1'b0, "R1 right after reset", right_o, '0);

      for (int k = 0; k < NVEC; k++) begin
         logic [54:0] v;
         string tag;
         v = VEC[k];
         tag = {fmt_tag(v[54:53]), " R5"};
         if (v[50]) tag = {tag, " R6"};
         if (v[49] || v[48]) tag = {tag, " R7"};
         run_frame(v[54:53], v[52:51], v[50], v[49], v[48], v[47:24], v[23:0], -1, 0, tag);
      end

      // prime left-justified slot timing with the guard off
      run_frame(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 24'h5A5A5A, 24'hC3C3C3, -1, 0, "R3 prime");
      // R9: glitch early in the right slot is rejected
      guard = 1'b1;
      run_frame(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 24'h13579B, 24'h2468AC, 1, 3, "R9 right glitch");
      // R9: glitch early in the left slot is rejected
      run_frame(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 24'h00ACE1, 24'h00BD02, 0, 2, "R9 left glitch");
      guard = 1'b0;

      // R8: outputs hold without new frames
      repeat (50) @(negedge clk);
      chk(left_o == 24'hACE100, "R8 hold left", left_o, 24'hACE100);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule